// File: doc/BRIEF.md
# Lane Bundle to Port Demultiplexer

This block takes one bundle of LANES parallel lanes. In any cycle each lane may carry one signal, and it spreads those signals over LANES single-signal output ports. Every lane has a valid bit, a payload and a port-select field that names the output port the payload should reach. When several valid lanes select the same port in the same cycle, one of them is delivered and the others are dropped. Each dropped lane raises a per-lane reject flag, so that an upstream controller can send those lanes again in a later pass.

The steering logic is combinational. It is followed by a single register stage, so results appear exactly one clock after the inputs are sampled. The block holds no queues and makes no retry decisions. Its only flow-control signals are valid and reject.

Top module: `bundle_port_demux`

## Requirements
- R1: One clock after a cycle with `rst` high, every bit of `out_valid`, `out_data` and `lane_reject` is zero.
- R2: A valid lane `l` whose port field `in_port[l*SEL_W +: SEL_W]` holds the value `p`, and that has no contender, has its payload `in_data[l*PAYLOAD_W +: PAYLOAD_W]` appear on `out_data[p*PAYLOAD_W +: PAYLOAD_W]`, with `out_valid[p]` set. SEL_W is the ceiling of log2(LANES), and at least 1.
- R3: When two or more valid lanes select the same port, only the lowest-numbered of them is delivered on that port. Lane 0 is therefore never rejected.
- R4: Each valid lane that loses arbitration has its bit in `lane_reject` set, in the same cycle that the outputs for that input cycle appear.
- R5: A lane with its valid bit low claims no port and is never rejected, whatever its port field and payload hold.
- R6: An output port that no valid lane selected drives `out_valid` low and a zero payload.
- R7: In every output cycle, the number of set bits in `out_valid` plus the number of set bits in `lane_reject` equals the number of valid lanes in the preceding input cycle.
- R8: The latency is exactly one clock. Outputs reflect only the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | LANES | Per-lane valid |
| in_port | input | LANES*SEL_W | Per-lane requested output port; lane l at bits l*SEL_W |
| in_data | input | LANES*PAYLOAD_W | Per-lane payload; lane l at bits l*PAYLOAD_W |
| out_valid | output | LANES | Per-port valid, registered |
| out_data | output | LANES*PAYLOAD_W | Per-port payload, registered; port p at bits p*PAYLOAD_W |
| lane_reject | output | LANES | Per-lane arbitration loss, registered |

## Verification
Several properties are checked on every cycle by the assertions:
- Every valid lane ends up either delivered or rejected, in matching numbers.
- A reject never appears for a lane that was not valid.
- Lane 0 is never rejected.
- Idle ports carry a zero payload.
- Reset clears all outputs.
- No output appears without an input on the cycle before.

Some behaviour only the bench scenarios can show, because it needs a model of the whole cycle:
- that the payload lands on the port its field names;
- that the winner among contenders is the lowest lane, rather than merely some lane;
- that the outputs track the inputs of the previous cycle rather than older ones.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  // Select-field width for a given port count, never below one bit.
  function automatic int unsigned sel_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/bpd_req_decode.sv
module bpd_req_decode #(
  parameter int LANES = 4,
  parameter int SEL_W = 2
) (
  input  logic [LANES-1:0]       lane_valid,
  input  logic [LANES*SEL_W-1:0] lane_port,
  output logic [LANES*LANES-1:0] req_by_port  // bit p*LANES+l: lane l wants port p
);
  always_comb begin
    req_by_port = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int p = 0; p < LANES; p++) begin
        if (lane_valid[l] && (lane_port[l*SEL_W +: SEL_W] == SEL_W'(p)))
          req_by_port[p*LANES + l] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bpd_port_arb.sv
module bpd_port_arb #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] req,
  output logic [LANES-1:0] grant,
  output logic             busy
);
  // Isolate the lowest set request bit: lowest lane has priority.
  assign grant = req & (~req + LANES'(1));
  assign busy  = |req;
endmodule

// File: rtl/bpd_out_reg.sv
module bpd_out_reg #(
  parameter int LANES     = 4,
  parameter int PAYLOAD_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LANES-1:0]             d_valid,
  input  logic [LANES*PAYLOAD_W-1:0]   d_data,
  input  logic [LANES-1:0]             d_reject,
  output logic [LANES-1:0]             q_valid,
  output logic [LANES*PAYLOAD_W-1:0]   q_data,
  output logic [LANES-1:0]             q_reject
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= '0;
      q_data   <= '0;
      q_reject <= '0;
    end else begin
      q_valid  <= d_valid;
      q_data   <= d_data;
      q_reject <= d_reject;
    end
  end
endmodule

// File: rtl/bundle_port_demux.sv
module bundle_port_demux
  import bpd_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int PAYLOAD_W = 8,
  localparam int SEL_W    = sel_width(LANES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LANES-1:0]           in_valid,
  input  logic [LANES*SEL_W-1:0]     in_port,
  input  logic [LANES*PAYLOAD_W-1:0] in_data,
  output logic [LANES-1:0]           out_valid,
  output logic [LANES*PAYLOAD_W-1:0] out_data,
  output logic [LANES-1:0]           lane_reject
);
  localparam int REQ_BITS = LANES * LANES;

  logic [REQ_BITS-1:0]        req_by_port;
  logic [REQ_BITS-1:0]        grant_by_port;
  logic [LANES-1:0]           port_busy;
  logic [LANES*PAYLOAD_W-1:0] port_data;
  logic [LANES-1:0]           lane_won;
  logic [LANES-1:0]           lane_lost;

  bpd_req_decode #(.LANES(LANES), .SEL_W(SEL_W)) u_decode (
    .lane_valid  (in_valid),
    .lane_port   (in_port),
    .req_by_port (req_by_port)
  );

  for (genvar p = 0; p < LANES; p++) begin : g_port
    bpd_port_arb #(.LANES(LANES)) u_arb (
      .req   (req_by_port[p*LANES +: LANES]),
      .grant (grant_by_port[p*LANES +: LANES]),
      .busy  (port_busy[p])
    );
  end

  // One-hot grant per port selects that port's payload; zero when idle.
  always_comb begin
    port_data = '0;
    lane_won  = '0;
    for (int p = 0; p < LANES; p++) begin
      for (int l = 0; l < LANES; l++) begin
        if (grant_by_port[p*LANES + l]) begin
          port_data[p*PAYLOAD_W +: PAYLOAD_W] =
            port_data[p*PAYLOAD_W +: PAYLOAD_W] | in_data[l*PAYLOAD_W +: PAYLOAD_W];
          lane_won[l] = 1'b1;
        end
      end
    end
  end

  assign lane_lost = in_valid & ~lane_won;

  bpd_out_reg #(.LANES(LANES), .PAYLOAD_W(PAYLOAD_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .d_valid  (port_busy),
    .d_data   (port_data),
    .d_reject (lane_lost),
    .q_valid  (out_valid),
    .q_data   (out_data),
    .q_reject (lane_reject)
  );
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker #(
  parameter int LANES     = 4,
  parameter int PAYLOAD_W = 8,
  parameter int SEL_W     = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic [LANES-1:0]           in_valid,
  input logic [LANES*SEL_W-1:0]     in_port,
  input logic [LANES*PAYLOAD_W-1:0] in_data,
  input logic [LANES-1:0]           out_valid,
  input logic [LANES*PAYLOAD_W-1:0] out_data,
  input logic [LANES-1:0]           lane_reject
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  assert_reset_clears_R1: assert property (@(posedge clk)
    (seen && $past(rst)) |-> (out_valid == '0 && lane_reject == '0 && out_data == '0));

  assert_lane0_never_loses_R3: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && $past(in_valid[0])) |-> !lane_reject[0]);

  assert_reject_only_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst)) |-> ((lane_reject & ~$past(in_valid)) == '0));

  for (genvar p = 0; p < LANES; p++) begin : g_idle
    assert_idle_port_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (seen && !out_valid[p]) |-> (out_data[p*PAYLOAD_W +: PAYLOAD_W] == '0));
  end

  assert_count_balance_R7: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst)) |->
      ($countones(out_valid) + $countones(lane_reject) == $countones($past(in_valid))));

  assert_no_output_without_input_R8: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && $past(in_valid) == '0) |-> (out_valid == '0 && lane_reject == '0));
endmodule

bind bundle_port_demux bpd_checker #(
  .LANES(LANES), .PAYLOAD_W(PAYLOAD_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_port(in_port), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data), .lane_reject(lane_reject)
);

// File: tb/sim_bundle_port_demux.sv
`timescale 1ns/1ps
module sim_bundle_port_demux;
  localparam int LANES = 4;
  localparam int PW    = 8;
  localparam int SW    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES-1:0]    in_valid = '0;
  logic [LANES*SW-1:0] in_port  = '0;
  logic [LANES*PW-1:0] in_data  = '0;
  logic [LANES-1:0]    out_valid;
  logic [LANES*PW-1:0] out_data;
  logic [LANES-1:0]    lane_reject;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bundle_port_demux #(.LANES(LANES), .PAYLOAD_W(PW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_port(in_port), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .lane_reject(lane_reject)
  );

  logic [LANES-1:0]    exp_valid;
  logic [LANES*PW-1:0] exp_data;
  logic [LANES-1:0]    exp_reject;

  // Reference model: each port is taken by the lowest valid lane naming it.
  task automatic model(input logic [LANES-1:0] v, input logic [LANES*SW-1:0] pt,
                       input logic [LANES*PW-1:0] d);
    logic [LANES-1:0] won;
    exp_valid = '0; exp_data = '0; won = '0;
    for (int p = 0; p < LANES; p++) begin
      for (int l = 0; l < LANES; l++) begin
        if (!exp_valid[p] && v[l] && pt[l*SW +: SW] == SW'(p)) begin
          exp_valid[p] = 1'b1;
          exp_data[p*PW +: PW] = d[l*PW +: PW];
          won[l] = 1'b1;
        end
      end
    end
    exp_reject = v & ~won;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [LANES-1:0] v, input logic [LANES*SW-1:0] pt,
                       input logic [LANES*PW-1:0] d, input string tag);
    @(negedge clk);
    in_valid = v; in_port = pt; in_data = d;
    model(v, pt, d);
    @(posedge clk);
    #1;
    check({tag, " R2 out_valid"}, 64'(out_valid), 64'(exp_valid));
    check({tag, " R6 out_data"}, 64'(out_data), 64'(exp_data));
    check({tag, " R4 lane_reject"}, 64'(lane_reject), 64'(exp_reject));
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", 64'(out_valid), 64'd0);
    check("R1 reset reject", 64'(lane_reject), 64'd0);
    @(negedge clk); rst = 1'b0;

    // R2: identity and reversed mappings, no contention
    apply(4'hF, {2'd3, 2'd2, 2'd1, 2'd0}, 32'hD4C3B2A1, "R2 identity");
    apply(4'hF, {2'd0, 2'd1, 2'd2, 2'd3}, 32'h44332211, "R2 reverse");
    // R3: all lanes on port 0, lane 0 wins
    apply(4'hF, {2'd0, 2'd0, 2'd0, 2'd0}, 32'h0A0B0C0D, "R3 all-to-0");
    // R3: lanes 1 and 3 contend on port 2, lane 1 wins
    apply(4'b1010, {2'd2, 2'd0, 2'd2, 2'd0}, 32'h9900EE00, "R3 pair");
    // R5: invalid lane 2 names port 1 but lane 3 still takes it
    apply(4'b1000, {2'd1, 2'd1, 2'd0, 2'd0}, 32'h77665544, "R5 invalid ignored");
    // R6/R8: nothing valid
    apply(4'h0, 8'hFF, 32'hFFFFFFFF, "R8 idle");
    // R1: reset mid-stream with busy inputs
    @(negedge clk);
    rst = 1'b1; in_valid = 4'hF; in_port = 8'h00; in_data = 32'h12345678;
    @(posedge clk); #1;
    check("R1 mid reset valid", 64'(out_valid), 64'd0);
    check("R1 mid reset data", 64'(out_data), 64'd0);
    check("R1 mid reset reject", 64'(lane_reject), 64'd0);
    @(negedge clk); rst = 1'b0;

    // R7/R8: random traffic
    void'($urandom(32'h5eed));
    for (int i = 0; i < 400; i++) begin
      apply(LANES'($urandom), (LANES*SW)'($urandom), (LANES*PW)'($urandom), "R7 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule